// File: doc/BRIEF.md
# PWM Time-Base Counter

This block produces the time base that a PWM generator compares against. A 16-bit counter advances once per prescaled clock enable and can count up, count down, count up then down, or stay frozen. Its rate comes from two cascaded divider stages: a high-speed stage and a power-of-two stage. The period lives in an active register. That register is either written directly or refreshed from a shadow copy each time the count passes zero.

Software-side logic configures the block through a one-word write port. Address 0 selects the control word and address 1 selects the period. The block reports the counter value, the prescaled enable, the direction of counting, and one-cycle zero-match and period-match events. A run-control field chooses how the counter stops, using a small state machine with three states. Halted means no counting. Running counts freely. Draining counts until the current cycle closes and then halts. The transitions are:

- Halted to Running when free run is selected.
- Running to Halted when stop-next is selected.
- Running to Draining when stop-at-end is selected.
- Draining to Halted when the counter lands on zero or stop-next is selected.
- Draining to Running when free run is selected again.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter is 0, the direction flag shows up-counting, both period registers are 0, the count mode is freeze, the run control is stop-next (state Halted), and no event fires.
- R2: Count mode (control bits [1:0]) 00 counts up by one per enable and wraps to 0 on the step taken when the count is at or above the period; the direction flag is 0.
- R3: Mode 01 counts down by one per enable and reloads the period on the step taken at 0; the direction flag is 1 after the first step.
- R4: Mode 10 counts up to the period, then down to 0, then up again; the direction flag becomes 1 on the step taken at the period and 0 on the step taken at 0; with period 0 the count stays 0 and the flag toggles each step.
- R5: Mode 11 freezes the counter and suppresses both events.
- R6: The enable pulses once every Dh*Dc clocks. Dc = 2^(bits [12:10]). Dh = 1 when bits [9:7] are 0 and twice that code otherwise. The counter changes only on enable cycles.
- R7: The zero event fires on an enable cycle in which the counter steps from 0, and the period event fires on one in which it steps from the active period value; each lasts one clock and never appears without the enable.
- R8: With control bit 3 at 0, a write to address 1 goes to the shadow period only, and the shadow is copied into the active period on the step taken from 0.
- R9: With control bit 3 at 1, a write to address 1 sets the active and shadow period at once; an up-count already above the new period wraps to 0 on its next step.
- R10: Run control (bits [15:14]) 00 halts the counter after at most one further step taken once the write lands (Running or Draining to Halted); a halted counter holds its value and fires no event.
- R11: Run control 01 lets the counter continue until a step lands on 0 (Running to Draining to Halted), then it holds at 0.
- R12: Run control 11 or 10 runs freely; selecting it while Halted resumes counting from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 1 | 0 selects control, 1 selects period |
| wr_data | input | 16 | Write data |
| cnt_o | output | 16 | Counter value |
| zero_o | output | 1 | Zero-match event |
| prd_o | output | 1 | Period-match event |
| dir_down_o | output | 1 | 1 while counting down |
| tick_o | output | 1 | Prescaled clock enable |

## Verification
Period 0 is a key corner. There an up-counter that compares with equality instead of at-or-above would never wrap, and an up-down counter without a guard would underflow to 0xFFFF. The shadow test writes the period mid-cycle and expects the old period to finish the cycle. A design that loads at once would cut the cycle short, and one that never loads would keep the old maximum. The immediate test lowers the period below the current count, which exposes any equality-only wrap. The stop tests pin the exact held value: 4 after a stop-next write issued at count 2, and 0 after a stop-at-end. An off-by-one in the state machine or a missed landing shows up there as a wrong count or a counter that never halts.

// File: rtl/pwm_tbc_pkg.sv
package pwm_tbc_pkg;

    typedef enum logic [1:0] {
        CM_UP     = 2'b00,
        CM_DOWN   = 2'b01,
        CM_UPDOWN = 2'b10,
        CM_FREEZE = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        RC_STOP_NEXT = 2'b00,
        RC_STOP_END  = 2'b01,
        RC_FREE_ALT  = 2'b10,
        RC_FREE      = 2'b11
    } run_ctl_e;

    typedef enum logic [1:0] {
        RS_HALT,
        RS_RUN,
        RS_DRAIN
    } run_state_e;

    // control word field positions (decoded by the top)
    localparam int MODE_LSB  = 0;
    localparam int PLOAD_BIT = 3;
    localparam int HSDIV_LSB = 7;
    localparam int CKDIV_LSB = 10;
    localparam int RUN_LSB   = 14;

endpackage

// File: rtl/tbc_prescaler.sv
module tbc_prescaler #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] hs_code,
    input  logic [CODE_W-1:0] ck_code,
    output logic              tick
);
    localparam int HS_W = CODE_W + 1;
    localparam int CK_W = 2 ** CODE_W;

    logic [HS_W-1:0] hs_q, hs_lim;
    logic [CK_W-1:0] ck_q, ck_lim;
    logic            hs_wrap, ck_wrap;

    // high-speed stage: 1 when code is 0, else 2*code
    always_comb begin
        if (hs_code == '0) hs_lim = '0;
        else               hs_lim = ({1'b0, hs_code} << 1) - HS_W'(1);
        ck_lim  = (CK_W'(1) << ck_code) - CK_W'(1);
        hs_wrap = (hs_q >= hs_lim);
        ck_wrap = (ck_q >= ck_lim);
    end

    assign tick = hs_wrap & ck_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '0;
            ck_q <= '0;
        end else if (hs_wrap) begin
            hs_q <= '0;
            ck_q <= ck_wrap ? '0 : ck_q + CK_W'(1);
        end else begin
            hs_q <= hs_q + HS_W'(1);
        end
    end
endmodule

// File: rtl/tbc_run_fsm.sv
module tbc_run_fsm
    import pwm_tbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  run_ctl_e   run_ctl,
    input  logic       lands_zero,
    output logic       run_en,
    output run_state_e state_o
);
    run_state_e state_q, state_d;
    logic       want_free;

    assign want_free = (run_ctl == RC_FREE) || (run_ctl == RC_FREE_ALT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_HALT: begin
                if (want_free) state_d = RS_RUN;
            end
            RS_RUN: begin
                if (run_ctl == RC_STOP_NEXT)     state_d = RS_HALT;
                else if (run_ctl == RC_STOP_END) state_d = RS_DRAIN;
            end
            RS_DRAIN: begin
                if (run_ctl == RC_STOP_NEXT) state_d = RS_HALT;
                else if (want_free)          state_d = RS_RUN;
                else if (lands_zero)         state_d = RS_HALT;
            end
            default: state_d = RS_HALT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RS_RUN, RS_DRAIN: run_en = 1'b1;
            default:          run_en = 1'b0;
        endcase
        state_o = state_q;
    end
endmodule

// File: rtl/tbc_counter.sv
module tbc_counter
    import pwm_tbc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  cnt_mode_e    mode,
    input  logic         prd_wr,
    input  logic         prd_imm,
    input  logic [W-1:0] prd_data,
    output logic [W-1:0] cnt,
    output logic         dir_down,
    output logic         zero_evt,
    output logic         prd_evt,
    output logic         lands_zero
);
    logic [W-1:0] cnt_q, cnt_d, act_q, shd_q, eff_prd;
    logic         dir_q, dir_d, step, load_shd;

    assign step     = advance && (mode != CM_FREEZE);
    assign load_shd = step && (cnt_q == '0) && !prd_imm;
    assign eff_prd  = load_shd ? shd_q : act_q;

    always_comb begin
        cnt_d = cnt_q;
        dir_d = dir_q;
        if (step) begin
            unique case (mode)
                CM_UP: begin
                    dir_d = 1'b0;
                    cnt_d = (cnt_q >= eff_prd) ? '0 : cnt_q + W'(1);
                end
                CM_DOWN: begin
                    dir_d = 1'b1;
                    cnt_d = (cnt_q == '0) ? eff_prd : cnt_q - W'(1);
                end
                CM_UPDOWN: begin
                    if (!dir_q) begin
                        if (cnt_q >= eff_prd) begin
                            dir_d = 1'b1;
                            cnt_d = (eff_prd == '0) ? '0 : cnt_q - W'(1);
                        end else begin
                            cnt_d = cnt_q + W'(1);
                        end
                    end else begin
                        if (cnt_q == '0) begin
                            dir_d = 1'b0;
                            cnt_d = (eff_prd == '0) ? '0 : W'(1);
                        end else begin
                            cnt_d = cnt_q - W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
            act_q <= '0;
            shd_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
            if (prd_wr && prd_imm) begin
                act_q <= prd_data;
                shd_q <= prd_data;
            end else begin
                if (prd_wr)   shd_q <= prd_data;
                if (load_shd) act_q <= shd_q;
            end
        end
    end

    assign cnt        = cnt_q;
    assign dir_down   = dir_q;
    assign zero_evt   = step && (cnt_q == '0);
    assign prd_evt    = step && (cnt_q == eff_prd);
    assign lands_zero = step && (cnt_d == '0);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tbc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CODE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o,
    output logic             prd_o,
    output logic             dir_down_o,
    output logic             tick_o
);
    cnt_mode_e       mode_q;
    run_ctl_e        run_q;
    logic            imm_q;
    logic [CODE_W-1:0] hs_code_q, ck_code_q;
    logic            ctl_wr, prd_wr, run_en, lands_zero, advance;
    run_state_e      run_state;
    logic            ctl_unused_bits;

    assign ctl_wr = wr_en && !wr_addr;
    assign prd_wr = wr_en &&  wr_addr;
    assign ctl_unused_bits = ^{wr_data[2], wr_data[6:4], wr_data[13]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= CM_FREEZE;
            run_q     <= RC_STOP_NEXT;
            imm_q     <= 1'b0;
            hs_code_q <= '0;
            ck_code_q <= '0;
        end else if (ctl_wr) begin
            mode_q    <= cnt_mode_e'(wr_data[MODE_LSB +: 2]);
            run_q     <= run_ctl_e'(wr_data[RUN_LSB +: 2]);
            imm_q     <= wr_data[PLOAD_BIT];
            hs_code_q <= wr_data[HSDIV_LSB +: CODE_W];
            ck_code_q <= wr_data[CKDIV_LSB +: CODE_W];
        end
    end

    tbc_prescaler #(.CODE_W(CODE_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_code (hs_code_q),
        .ck_code (ck_code_q),
        .tick    (tick_o)
    );

    tbc_run_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_ctl    (run_q),
        .lands_zero (lands_zero),
        .run_en     (run_en),
        .state_o    (run_state)
    );

    assign advance = tick_o && run_en;

    tbc_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .mode       (mode_q),
        .prd_wr     (prd_wr),
        .prd_imm    (imm_q),
        .prd_data   (wr_data),
        .cnt        (cnt_o),
        .dir_down   (dir_down_o),
        .zero_evt   (zero_o),
        .prd_evt    (prd_o),
        .lands_zero (lands_zero)
    );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
    import pwm_tbc_pkg::*;
#(
    parameter int W      = 16,
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              tick_o,
    input logic              zero_o,
    input logic              prd_o,
    input logic              dir_down_o,
    input logic [W-1:0]      cnt_o,
    input logic              run_en,
    input run_state_e        run_state,
    input cnt_mode_e         mode_q,
    input logic [CODE_W-1:0] hs_code_q,
    input logic [CODE_W-1:0] ck_code_q
);
    logic slow_div;
    assign slow_div = (hs_code_q != '0) || (ck_code_q != '0);

    assert_evt_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o || prd_o) |-> tick_o);

    assert_single_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && slow_div && !wr_en) |=> !zero_o);

    assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |=> $stable(cnt_o));

    assert_prescale_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && slow_div && !wr_en) |=> !tick_o);

    assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && run_en && mode_q == CM_UP) |=>
            ((cnt_o == $past(cnt_o) + W'(1)) || (cnt_o == '0)));

    assert_up_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && run_en && mode_q == CM_UP) |=> !dir_down_o);

    assert_down_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && run_en && mode_q == CM_DOWN) |=>
            ((cnt_o < $past(cnt_o)) || ($past(cnt_o) == '0)));

    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == RS_HALT) |=> $stable(cnt_o));
endmodule

bind pwm_timebase pwm_timebase_chk #(.W(CNT_W), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .tick_o     (tick_o),
    .zero_o     (zero_o),
    .prd_o      (prd_o),
    .dir_down_o (dir_down_o),
    .cnt_o      (cnt_o),
    .run_en     (run_en),
    .run_state  (run_state),
    .mode_q     (mode_q),
    .hs_code_q  (hs_code_q),
    .ck_code_q  (ck_code_q)
);

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;

    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] prd;
        logic [31:0] seq;   // expected count at each enable, sample i in nibble i
        logic [7:0]  dirs;  // expected direction flag, sample i in bit i
        logic [7:0]  gap;   // expected clocks between enables
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{16'hC008, 16'd3, 32'h32103210, 8'h00, 8'd1},  // up, /1
        '{16'hC189, 16'd3, 32'h12301230, 8'hFE, 8'd6},  // down, hs code 3
        '{16'hC80A, 16'd3, 32'h10123210, 8'h70, 8'd4},  // up-down, ck code 2
        '{16'hC508, 16'd0, 32'h00000000, 8'h00, 8'd8},  // up, period 0, hs2 ck1
        '{16'hC08B, 16'd5, 32'h00000000, 8'h00, 8'd2},  // freeze, hs1
        '{16'hC00A, 16'd0, 32'h00000000, 8'hAA, 8'd1},  // up-down, period 0
        '{16'hC009, 16'd1, 32'h10101010, 8'hFE, 8'd1}   // down, period 1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] cnt_o;
    logic        zero_o, prd_o, dir_down_o, tick_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    pwm_timebase u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cnt_o      (cnt_o),
        .zero_o     (zero_o),
        .prd_o      (prd_o),
        .dir_down_o (dir_down_o),
        .tick_o     (tick_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<=50000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // register port: address 0 control, address 1 period
    task automatic wr(input logic a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input logic [15:0] ctrl, input logic [15:0] prd);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        wr(1'b0, 16'h000B);
        wr(1'b1, prd);
        wr(1'b0, ctrl);
    endtask

    initial begin
        int mx;
        @(negedge clk);

        // vector table walk: R2 R3 R4 R5 R6 R7
        for (int e = 0; e < NV; e++) begin
            int n, cyc, last, prev, stray;
            logic frz;
            setup(VECS[e].ctrl, VECS[e].prd);
            frz = (VECS[e].ctrl[1:0] == 2'b11);
            @(negedge clk);
            n = 0; cyc = 0; last = -1; prev = -1; stray = 0;
            while (n < 8 && cyc < 300) begin
                if ((zero_o || prd_o) && !tick_o) stray++;
                if (tick_o) begin
                    int ec;
                    ec = int'(VECS[e].seq[4*n +: 4]);
                    chk($sformatf("R2/R3/R4/R5 v%0d s%0d count", e, n), int'(cnt_o), ec);
                    chk($sformatf("R4 v%0d s%0d dir", e, n), int'(dir_down_o), int'(VECS[e].dirs[n]));
                    chk($sformatf("R7 v%0d s%0d zero", e, n), int'(zero_o),
                        int'(!frz && ec == 0));
                    chk($sformatf("R7 v%0d s%0d period", e, n), int'(prd_o),
                        int'(!frz && ec == int'(VECS[e].prd)));
                    prev = last; last = cyc; n++;
                end
                cyc++;
                @(negedge clk);
            end
            chk($sformatf("R6 v%0d enable gap", e), last - prev, int'(VECS[e].gap));
            chk($sformatf("R7 v%0d events off enable", e), stray, 0);
        end

        // R1: reset state, then period 0 left by reset
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 count after reset", int'(cnt_o), 0);
        chk("R1 dir after reset", int'(dir_down_o), 0);
        chk("R1 events after reset", int'(zero_o || prd_o), 0);
        wr(1'b0, 16'hC000);
        @(negedge clk);
        chk("R1 reset period is 0 (period event)", int'(prd_o), 1);
        chk("R1 reset period is 0 (count)", int'(cnt_o), 0);

        // R8: shadow write takes effect only after the count passes zero
        setup(16'hC000, 16'd5);
        while (cnt_o != 16'd1) @(negedge clk);
        wr(1'b1, 16'd2);
        mx = 0;
        for (int i = 0; i < 20 && cnt_o != 0; i++) begin
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
            @(negedge clk);
        end
        chk("R8 old period finishes cycle", mx, 5);
        mx = 0;
        for (int i = 0; i < 12; i++) begin
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
            @(negedge clk);
        end
        chk("R8 shadow period used after zero", mx, 2);

        // R9: immediate write below current count
        setup(16'hC008, 16'd5);
        while (cnt_o != 16'd4) @(negedge clk);
        wr(1'b1, 16'd2);
        chk("R9 step after write", int'(cnt_o), 5);
        @(negedge clk);
        chk("R9 wrap above new period", int'(cnt_o), 0);
        repeat (2) @(negedge clk);
        chk("R9 new period reached", int'(cnt_o), 2);
        chk("R9 period event at new period", int'(prd_o), 1);

        // R11: stop at end of cycle
        setup(16'hC008, 16'd5);
        while (cnt_o != 16'd2) @(negedge clk);
        wr(1'b0, 16'h4008);
        mx = 0;
        for (int i = 0; i < 30; i++) begin
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
            @(negedge clk);
        end
        chk("R11 cycle completed", mx, 5);
        chk("R11 held at zero", int'(cnt_o), 0);
        chk("R11 no event when halted", int'(zero_o || prd_o), 0);

        // R10: stop on next count, then R12 restart
        setup(16'hC008, 16'd5);
        while (cnt_o != 16'd2) @(negedge clk);
        wr(1'b0, 16'h0008);
        repeat (5) @(negedge clk);
        chk("R10 held value", int'(cnt_o), 4);
        chk("R10 no event when halted", int'(zero_o || prd_o), 0);
        wr(1'b0, 16'hC008);
        repeat (2) @(negedge clk);
        chk("R12 resumes from held value", int'(cnt_o), 5);

        // R12: code 10 also runs freely
        setup(16'h8008, 16'd5);
        repeat (2) @(negedge clk);
        chk("R12 alternate free-run code", int'(cnt_o), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule